// File: doc/BRIEF.md
# Floating-Point Control and Status Word

This block keeps the single 32-bit control and status word of a scalar floating-point unit. Software reaches it through move-to-control and move-from-control requests that carry a 5-bit control register index. The arithmetic datapath reports the outcome of each operation to it. That report carries five exception bits, an unimplemented-operation bit and an optional write of one of eight condition codes.

The block returns the current rounding mode and the eight condition codes. When an operation completes, it also returns two results. One is a trap request, raised when a cause bit meets its enable. The other is a write-back enable, which tells the datapath whether the destination register may be updated. A trap always withholds the write-back, so a trapping operation leaves neither a result nor a condition code behind.

Word layout:

| Bits | Field |
|------|-------|
| 1:0 | rounding mode |
| 6:2 | sticky flags |
| 11:7 | enables |
| 16:12 | cause |
| 17 | unimplemented-operation cause |
| 23 | condition code 0 |
| 24 | flush-to-zero |
| 31:25 | condition codes 1 to 7 |

Within each 5-bit exception group the bit order is:

| Bit | Exception |
|-----|-----------|
| 0 | inexact |
| 1 | underflow |
| 2 | overflow |
| 3 | divide-by-zero |
| 4 | invalid |

Top module: `fcsr_top`

## Requirements
- R1: A read with index 31 returns the word on `rd_data` one cycle after the request. A read with any other index, including 0, returns zero. A read issued in the same cycle as a write returns the value the word had before that write.
- R2: A control write updates only bit 24 and bits 11:0 of the word. All other bits keep their previous value.
- R3: A control write with `ctl_src_zero` high writes the value zero, whatever `ctl_wdata` carries.
- R4: An operation overwrites all of cause bits 17:12 with `{op_unimpl, op_exc}`. Each raised exception bit also sets the matching flag in bits 6:2. Flags are never cleared except by a control write.
- R5: `trap_req` is high in the cycle after an operation if any cause bit in 16:12 is set together with its enable bit five positions lower (11:7). In that case `wb_en` is low and no condition code is written. Otherwise `wb_en` is high for one cycle after each operation.
- R6: The same trap check also follows every control write, using the cause bits held in the word and the enable bits just written.
- R7: A condition code write that accompanies an operation sets the code selected by the 3-bit `cc_sel` to `cc_val`. Code 0 sits at bit 23 and code k (k = 1 to 7) sits at bit 24+k. `cond_codes[k]` shows code k.
- R8: `round_mode` shows bits 1:0 of the word: 0 round to nearest, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity.
- R9: Reset clears the word, `rd_data`, `trap_req` and `wb_en`.
- R10: The unimplemented-operation cause bit 17 raises a trap regardless of the enable bits, after an operation and after a control write alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Move-to-control request |
| ctl_rd_en | input | 1 | Move-from-control request |
| ctl_idx | input | 5 | Control register index |
| ctl_src_zero | input | 1 | Source is general register 0 |
| ctl_wdata | input | 32 | Data for a control write |
| rd_data | output | 32 | Read result, registered |
| op_valid | input | 1 | An arithmetic operation completes |
| op_exc | input | 5 | Exceptions of that operation |
| op_unimpl | input | 1 | Operation was unimplemented |
| cc_wr_en | input | 1 | Operation writes a condition code |
| cc_sel | input | 3 | Condition code index |
| cc_val | input | 1 | Condition code value |
| round_mode | output | 2 | Current rounding mode |
| cond_codes | output | 8 | Condition codes 0 to 7 |
| trap_req | output | 1 | Trap request |
| wb_en | output | 1 | Result write-back allowed |

## Verification
The write mask is tried with data patterns that are all ones, all zeros, only locked bits, and alternating bits. Together these separate mask bits that are writable from those that are held. They also show whether bits 1:0 reach the rounding mode unchanged. Operation sequences that raise different exceptions in turn distinguish a cause field that is replaced from one that is accumulated. Enable patterns set before and after a cause is present distinguish the check that follows an operation from the one that follows a control write. Condition code writes to indices 0 and 5 check that the split bit positions map correctly. A trapping condition code write checks that a trap suppresses it.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int WORD_W     = 32;
  localparam int IDX_W      = 5;
  localparam int N_EXC      = 5;
  localparam int N_CC       = 8;
  localparam int CC_SEL_W   = 3;
  localparam int RM_W       = 2;
  localparam int FLAG_LO    = 2;
  localparam int EN_LO      = FLAG_LO + N_EXC;
  localparam int CAUSE_LO   = EN_LO + N_EXC;
  localparam int UNIMPL_BIT = CAUSE_LO + N_EXC;
  localparam int CC0_BIT    = 23;
  localparam int FLUSH_BIT  = 24;
  localparam int CC_HI_LO   = 25;
  localparam int CSR_INDEX  = 31;

  // writable by software: flush, enables, flags, rounding mode
  localparam logic [WORD_W-1:0] WR_MASK =
      ((WORD_W'(1) << CAUSE_LO) - WORD_W'(1)) | (WORD_W'(1) << FLUSH_BIT);

  typedef enum logic [RM_W-1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_PLUS    = 2'd2,
    RM_MINUS   = 2'd3
  } rmode_e;

  function automatic int cc_pos(input int sel);
    return (sel == 0) ? CC0_BIT : CC_HI_LO + sel - 1;
  endfunction
endpackage

// File: rtl/fcsr_wr_merge.sv
module fcsr_wr_merge
  import fcsr_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  logic              wr_en,
  input  logic              src_zero,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word_out
);
  logic [WORD_W-1:0] src;

  always_comb begin
    src      = src_zero ? '0 : wdata;
    word_out = wr_en ? ((word_in & ~WR_MASK) | (src & WR_MASK)) : word_in;
  end
endmodule

// File: rtl/fcsr_exc_update.sv
module fcsr_exc_update
  import fcsr_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  logic              op_valid,
  input  logic [N_EXC-1:0]  exc,
  input  logic              unimpl,
  output logic [WORD_W-1:0] word_out
);
  always_comb begin
    word_out = word_in;
    if (op_valid) begin
      word_out[UNIMPL_BIT:CAUSE_LO]     = {unimpl, exc};
      word_out[EN_LO-1:FLAG_LO]         = word_in[EN_LO-1:FLAG_LO] | exc;
    end
  end
endmodule

// File: rtl/fcsr_trap_eval.sv
module fcsr_trap_eval
  import fcsr_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  logic              check,
  output logic              trap
);
  logic [N_EXC-1:0] armed;

  always_comb begin
    armed = word_in[CAUSE_LO +: N_EXC] & word_in[EN_LO +: N_EXC];
    trap  = check & ((|armed) | word_in[UNIMPL_BIT]);
  end
endmodule

// File: rtl/fcsr_top.sv
module fcsr_top
  import fcsr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_wr_en,
  input  logic                ctl_rd_en,
  input  logic [IDX_W-1:0]    ctl_idx,
  input  logic                ctl_src_zero,
  input  logic [WORD_W-1:0]   ctl_wdata,
  output logic [WORD_W-1:0]   rd_data,
  input  logic                op_valid,
  input  logic [N_EXC-1:0]    op_exc,
  input  logic                op_unimpl,
  input  logic                cc_wr_en,
  input  logic [CC_SEL_W-1:0] cc_sel,
  input  logic                cc_val,
  output logic [RM_W-1:0]     round_mode,
  output logic [N_CC-1:0]     cond_codes,
  output logic                trap_req,
  output logic                wb_en
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] after_wr, after_op, after_cc;
  logic              csr_wr, trap_now;

  assign csr_wr = ctl_wr_en && (ctl_idx == IDX_W'(CSR_INDEX));

  fcsr_wr_merge u_wr (
    .word_in (word_q), .wr_en(csr_wr), .src_zero(ctl_src_zero),
    .wdata   (ctl_wdata), .word_out(after_wr)
  );

  fcsr_exc_update u_exc (
    .word_in (after_wr), .op_valid(op_valid), .exc(op_exc),
    .unimpl  (op_unimpl), .word_out(after_op)
  );

  fcsr_trap_eval u_trap (
    .word_in (after_op), .check(op_valid | ctl_wr_en), .trap(trap_now)
  );

  // condition code write is part of the result: suppressed by a trap
  always_comb begin
    after_cc = after_op;
    if (op_valid && cc_wr_en && !trap_now)
      after_cc[cc_pos(int'(cc_sel))] = cc_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q   <= '0;
      rd_data  <= '0;
      trap_req <= 1'b0;
      wb_en    <= 1'b0;
    end else begin
      word_q   <= after_cc;
      trap_req <= trap_now;
      wb_en    <= op_valid & ~trap_now;
      if (ctl_rd_en)
        rd_data <= (ctl_idx == IDX_W'(CSR_INDEX)) ? word_q : '0;
    end
  end

  assign round_mode = word_q[RM_W-1:0];

  for (genvar g = 0; g < N_CC; g++) begin : g_cc
    localparam int POS = (g == 0) ? CC0_BIT : CC_HI_LO + g - 1;
    assign cond_codes[g] = word_q[POS];
  end

  // R5: a trap never coexists with write-back
  a_r5_trap_blocks_wb: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> !wb_en);

  // R6: trap only follows an operation or a control write
  a_r6_trap_has_source: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(op_valid || ctl_wr_en));

  // R5: write-back only follows an operation
  a_r5_wb_after_op: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> $past(op_valid));

  // R4: flags are sticky unless software writes the word
  a_r4_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !csr_wr |=> ((word_q[EN_LO-1:FLAG_LO] & $past(word_q[EN_LO-1:FLAG_LO]))
                 == $past(word_q[EN_LO-1:FLAG_LO])));

  // R2: a control write alone leaves locked bits untouched
  a_r2_locked_bits: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && !op_valid) |=> ((word_q & ~WR_MASK) == ($past(word_q) & ~WR_MASK)));
endmodule

// File: tb/test_fcsr_top.sv
module test_fcsr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr_en = 0, ctl_rd_en = 0, ctl_src_zero = 0;
  logic [4:0]  ctl_idx = 0;
  logic [31:0] ctl_wdata = 0;
  logic [31:0] rd_data;
  logic        op_valid = 0, op_unimpl = 0, cc_wr_en = 0, cc_val = 0;
  logic [4:0]  op_exc = 0;
  logic [2:0]  cc_sel = 0;
  logic [1:0]  round_mode;
  logic [7:0]  cond_codes;
  logic        trap_req, wb_en;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fcsr_top i_fcsr_top (
    .clk(clk), .rst(rst), .ctl_wr_en(ctl_wr_en), .ctl_rd_en(ctl_rd_en),
    .ctl_idx(ctl_idx), .ctl_src_zero(ctl_src_zero), .ctl_wdata(ctl_wdata),
    .rd_data(rd_data), .op_valid(op_valid), .op_exc(op_exc),
    .op_unimpl(op_unimpl), .cc_wr_en(cc_wr_en), .cc_sel(cc_sel),
    .cc_val(cc_val), .round_mode(round_mode), .cond_codes(cond_codes),
    .trap_req(trap_req), .wb_en(wb_en)
  );

  // {write data, expected word}
  localparam logic [63:0] VEC [5] = '{
    {32'hFFFF_FFFF, 32'h0100_0FFF},
    {32'h0000_0000, 32'h0000_0000},
    {32'hFEFF_F000, 32'h0000_0000},
    {32'h0000_0002, 32'h0000_0002},
    {32'h0100_0555, 32'h0100_0555}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    ctl_wr_en = 0; ctl_rd_en = 0; ctl_src_zero = 0; ctl_idx = 0; ctl_wdata = 0;
    op_valid = 0; op_exc = 0; op_unimpl = 0; cc_wr_en = 0; cc_sel = 0; cc_val = 0;
  endtask

  task automatic wr(input logic [31:0] d, input logic z);
    ctl_wr_en = 1; ctl_idx = 5'd31; ctl_wdata = d; ctl_src_zero = z;
    step(); idle();
  endtask

  task automatic rd(input logic [4:0] idx, output logic [31:0] v);
    ctl_rd_en = 1; ctl_idx = idx;
    step(); idle();
    v = rd_data;
  endtask

  task automatic op(input logic [4:0] e, input logic u, input logic ccw,
                    input logic [2:0] sel, input logic val);
    op_valid = 1; op_exc = e; op_unimpl = u; cc_wr_en = ccw; cc_sel = sel; cc_val = val;
    step(); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) step();
    rst = 0;
    // R9 reset state
    check("R9 trap", {31'd0, trap_req}, 0);
    check("R9 wb", {31'd0, wb_en}, 0);
    check("R9 cc", {24'd0, cond_codes}, 0);
    check("R9 rd_data", rd_data, 0);
    rd(5'd31, v); check("R9 word", v, 0);

    // R2 / R8 table walk
    foreach (VEC[i]) begin
      wr(VEC[i][63:32], 1'b0);
      check("R6 no trap on plain write", {31'd0, trap_req}, 0);
      rd(5'd31, v);
      check("R2 masked write", v, VEC[i][31:0]);
      check("R8 round mode", {30'd0, round_mode}, {30'd0, VEC[i][1:0]});
    end

    // R3
    wr(32'h0000_0FFF, 1'b1);
    rd(5'd31, v); check("R3 zero source", v, 0);

    // R1 read in same cycle as write sees old value
    ctl_wr_en = 1; ctl_rd_en = 1; ctl_idx = 5'd31; ctl_wdata = 32'h3;
    step(); idle();
    check("R1 read during write", rd_data, 0);
    rd(5'd31, v); check("R1 read after write", v, 32'h3);
    check("R8 toward minus", {30'd0, round_mode}, 32'h3);
    wr(32'h555, 1'b0);
    rd(5'd0, v);  check("R1 index 0", v, 0);
    rd(5'd7, v);  check("R1 other index", v, 0);
    rd(5'd31, v); check("R1 index 31", v, 32'h555);
    wr(32'h0, 1'b0);

    // R4 cause replace, flags accumulate
    op(5'b00001, 0, 0, 0, 0);
    check("R4 wb", {31'd0, wb_en}, 1);
    check("R4 no trap", {31'd0, trap_req}, 0);
    rd(5'd31, v); check("R4 inexact", v, 32'h0000_1004);
    op(5'b00100, 0, 0, 0, 0);
    rd(5'd31, v); check("R4 cause replaced", v, 32'h0000_4014);
    op(5'b00000, 0, 0, 0, 0);
    rd(5'd31, v); check("R4 flags kept", v, 32'h0000_0014);

    // R5 trap after operation blocks result and cc
    wr(32'h200, 1'b0);
    check("R5 enable alone no trap", {31'd0, trap_req}, 0);
    op(5'b00100, 0, 1, 3'd3, 1);
    check("R5 trap", {31'd0, trap_req}, 1);
    check("R5 wb blocked", {31'd0, wb_en}, 0);
    check("R5 cc blocked", {24'd0, cond_codes}, 0);
    rd(5'd31, v); check("R5 word", v, 32'h0000_4210);

    // R6 trap after control write
    wr(32'h0, 1'b0);
    check("R6 disabled no trap", {31'd0, trap_req}, 0);
    wr(32'h200, 1'b0);
    check("R6 enable with pending cause", {31'd0, trap_req}, 1);
    rd(5'd31, v); check("R6 word", v, 32'h0000_4200);

    // R7 condition codes
    wr(32'h0, 1'b0);
    op(5'b0, 0, 1, 3'd0, 1);
    check("R7 wb", {31'd0, wb_en}, 1);
    check("R7 cc0", {24'd0, cond_codes}, 32'h01);
    op(5'b0, 0, 1, 3'd5, 1);
    check("R7 cc5", {24'd0, cond_codes}, 32'h21);
    rd(5'd31, v); check("R7 positions", v, 32'h2080_0000);
    op(5'b0, 0, 1, 3'd0, 0);
    check("R7 cc0 cleared", {24'd0, cond_codes}, 32'h20);

    // R10 unimplemented cause always traps
    op(5'b0, 1, 0, 0, 0);
    check("R10 trap after op", {31'd0, trap_req}, 1);
    check("R10 wb blocked", {31'd0, wb_en}, 0);
    rd(5'd31, v); check("R10 word", v, 32'h2002_0000);
    wr(32'h0, 1'b0);
    check("R10 trap after write", {31'd0, trap_req}, 1);
    op(5'b0, 0, 0, 0, 0);
    check("R10 cleared", {31'd0, trap_req}, 0);
    check("R10 wb back", {31'd0, wb_en}, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule